// File: doc/BRIEF.md
# Complementary Gate-Pair Pulse Generator with Dead Band

This block drives the two switches of a synchronous step-down power stage. It produces a high-side gate command and a low-side gate command that alternate: the high side is commanded during an ON interval and the low side during an OFF interval. One switching period is the ON interval followed by the OFF interval. Each interval is a count of block clocks, and the output changes phase whenever the running interval expires. The duty ratio is therefore ON / (ON + OFF), and the average voltage delivered to the load scales with it. As an example, a 10 kHz switching rate with a 200 MHz block clock needs ON + OFF = 20000.

A dead band is cut from the front of each interval. Each gate rises only after the dead-band count of clocks has elapsed in its own interval. The two switches therefore never conduct together, and each gate change is preceded by a gap in which both are off. New ON, OFF and dead-band counts enter through a separate update strobe. They are held in shadow storage and take effect only when the next period starts, so a period that is already running is never cut short or stretched. A one-clock period-start pulse marks the first clock of every ON interval, so that downstream sampling logic can stay in step with the switching.

Top module: `gate_pair_pwm`

## Requirements
- R1: While reset is asserted or `run_en` is low, `gate_hs`, `gate_ls` and `cycle_mark` are all 0. After `run_en` goes low and then high again, a new period starts from the beginning of its ON interval.
- R2: `gate_hs` can be 1 only during the ON interval, and `gate_ls` only during the OFF interval. They are never 1 in the same clock.
- R3: Let d be the dead-band count. Within an interval of length L, the gate for that interval is low for the first d clocks and high for the remaining L-d clocks.
- R4: If an interval is no longer than the dead-band count, its gate stays low for the whole of that interval.
- R5: The first clock after `run_en` is sampled high is clock 0 of an ON interval. A period lasts exactly ON + OFF clocks: ON clocks of ON interval, then OFF clocks of OFF interval.
- R6: `cycle_mark` is 1 for exactly the first clock of each ON interval and 0 otherwise.
- R7: A clock edge with `load_stb` high captures `on_len`, `off_len` and `dead_len` into shadow storage. They apply from the next period start, and the period in progress keeps its old counts. If several strobes arrive before a period start, the last one wins.
- R8: An ON or OFF count of 0 is treated as 1 clock.
- R9: A strobe on the same edge at which a new period begins applies to that new period.
- R10: After reset, the shadow counts are ON = 4, OFF = 4 and dead band = 1 (parameter defaults). These apply if the block is enabled before any strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Enables switching; low forces both gates off |
| on_len | input | CNT_W | ON interval length in clocks, captured on strobe |
| off_len | input | CNT_W | OFF interval length in clocks, captured on strobe |
| dead_len | input | DT_W | Dead-band length in clocks, captured on strobe |
| load_stb | input | 1 | Captures the three lengths into shadow storage |
| gate_hs | output | 1 | High-side gate command |
| gate_ls | output | 1 | Low-side gate command |
| cycle_mark | output | 1 | One-clock pulse at each period start |

## Verification
The gap checks between the two gates take for granted that every dead-band value the block can hold is at least 1. A value of 0 would let one gate rise in the same clock that the other falls. The reset default is 1, and the stimulus never strobes a dead-band value below 1. The period-start check assumes every period is at least two clocks long, which the zero-as-one rule guarantees. The stimulus keeps `load_stb` and the lengths stable between falling edges, and drives them only there.

// File: rtl/gate_pair_pwm_pkg.sv
package gate_pair_pwm_pkg;
   typedef enum logic {
      PH_HS = 1'b0,
      PH_LS = 1'b1
   } phase_e;
endpackage

// File: rtl/gate_pair_pwm_shadow.sv
module gate_pair_pwm_shadow #(
   parameter int CNT_W   = 16,
   parameter int DT_W    = 8,
   parameter int RST_ON  = 4,
   parameter int RST_OFF = 4,
   parameter int RST_DT  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_stb,
   input  logic [CNT_W-1:0] on_len,
   input  logic [CNT_W-1:0] off_len,
   input  logic [DT_W-1:0]  dead_len,
   output logic [CNT_W-1:0] nxt_on,
   output logic [CNT_W-1:0] nxt_off,
   output logic [DT_W-1:0]  nxt_dt
);
   logic [CNT_W-1:0] sh_on, sh_off;
   logic [DT_W-1:0]  sh_dt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_on  <= CNT_W'(RST_ON);
         sh_off <= CNT_W'(RST_OFF);
         sh_dt  <= DT_W'(RST_DT);
      end else if (load_stb) begin
         sh_on  <= on_len;
         sh_off <= off_len;
         sh_dt  <= dead_len;
      end
   end

   // A strobe on a period-start edge reaches the new period directly
   always_comb begin
      nxt_on  = load_stb ? on_len   : sh_on;
      nxt_off = load_stb ? off_len  : sh_off;
      nxt_dt  = load_stb ? dead_len : sh_dt;
   end
endmodule

// File: rtl/gate_pair_pwm_timer.sv
module gate_pair_pwm_timer
   import gate_pair_pwm_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int DT_W    = 8,
   parameter int RST_ON  = 4,
   parameter int RST_OFF = 4,
   parameter int RST_DT  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [CNT_W-1:0] nxt_on,
   input  logic [CNT_W-1:0] nxt_off,
   input  logic [DT_W-1:0]  nxt_dt,
   output logic             live,
   output phase_e           phase,
   output logic [CNT_W-1:0] tick,
   output logic [DT_W-1:0]  act_dt
);
   logic [CNT_W-1:0] act_on, act_off, len_on, len_off, cur_len;
   logic             running;

   always_comb begin
      len_on  = (act_on  == '0) ? CNT_W'(1) : act_on;
      len_off = (act_off == '0) ? CNT_W'(1) : act_off;
      cur_len = (phase == PH_HS) ? len_on : len_off;
      live    = running & run_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         phase   <= PH_HS;
         tick    <= '0;
         act_on  <= CNT_W'(RST_ON);
         act_off <= CNT_W'(RST_OFF);
         act_dt  <= DT_W'(RST_DT);
      end else if (!run_en) begin
         running <= 1'b0;
         phase   <= PH_HS;
         tick    <= '0;
      end else if (!running) begin
         running <= 1'b1;
         phase   <= PH_HS;
         tick    <= '0;
         act_on  <= nxt_on;
         act_off <= nxt_off;
         act_dt  <= nxt_dt;
      end else if (tick == cur_len - CNT_W'(1)) begin
         tick <= '0;
         if (phase == PH_LS) begin
            phase   <= PH_HS;
            act_on  <= nxt_on;
            act_off <= nxt_off;
            act_dt  <= nxt_dt;
         end else begin
            phase <= PH_LS;
         end
      end else begin
         tick <= tick + CNT_W'(1);
      end
   end
endmodule

// File: rtl/gate_pair_pwm_deadband.sv
module gate_pair_pwm_deadband #(
   parameter int CNT_W   = 16,
   parameter int DT_W    = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             own_phase,
   input  logic [CNT_W-1:0] tick,
   input  logic [DT_W-1:0]  dead,
   output logic             gate
);
   logic raw;

   always_comb raw = own_phase && (tick >= CNT_W'(dead));

   if (OUT_REG) begin : g_reg
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= raw;
      end
      assign gate = q;
   end else begin : g_comb
      assign gate = raw;
   end
endmodule

// File: rtl/gate_pair_pwm.sv
module gate_pair_pwm
   import gate_pair_pwm_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int DT_W    = 8,
   parameter int RST_ON  = 4,
   parameter int RST_OFF = 4,
   parameter int RST_DT  = 1,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [CNT_W-1:0] on_len,
   input  logic [CNT_W-1:0] off_len,
   input  logic [DT_W-1:0]  dead_len,
   input  logic             load_stb,
   output logic             gate_hs,
   output logic             gate_ls,
   output logic             cycle_mark
);
   localparam int NCH = 2;

   if (CNT_W < 2)                    begin : g_bad_cnt  $error("CNT_W must be at least 2");          end
   if (DT_W < 1 || DT_W > CNT_W)     begin : g_bad_dt   $error("DT_W must lie in 1..CNT_W");         end
   if (RST_DT < 1)                   begin : g_bad_rdt  $error("RST_DT must be at least 1");         end
   if (RST_DT >= (1 << DT_W))        begin : g_wide_rdt $error("RST_DT does not fit DT_W");          end

   logic [CNT_W-1:0] nxt_on, nxt_off, tick;
   logic [DT_W-1:0]  nxt_dt, act_dt;
   logic             live;
   phase_e           phase;
   logic [NCH-1:0]   own, gates;
   logic             mark_raw;

   gate_pair_pwm_shadow #(
      .CNT_W(CNT_W), .DT_W(DT_W),
      .RST_ON(RST_ON), .RST_OFF(RST_OFF), .RST_DT(RST_DT)
   ) u_shadow (
      .clk(clk), .rst_n(rst_n), .load_stb(load_stb),
      .on_len(on_len), .off_len(off_len), .dead_len(dead_len),
      .nxt_on(nxt_on), .nxt_off(nxt_off), .nxt_dt(nxt_dt)
   );

   gate_pair_pwm_timer #(
      .CNT_W(CNT_W), .DT_W(DT_W),
      .RST_ON(RST_ON), .RST_OFF(RST_OFF), .RST_DT(RST_DT)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .run_en(run_en),
      .nxt_on(nxt_on), .nxt_off(nxt_off), .nxt_dt(nxt_dt),
      .live(live), .phase(phase), .tick(tick), .act_dt(act_dt)
   );

   always_comb begin
      own[0]   = live && (phase == PH_HS);
      own[1]   = live && (phase == PH_LS);
      mark_raw = own[0] && (tick == '0);
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      gate_pair_pwm_deadband #(
         .CNT_W(CNT_W), .DT_W(DT_W), .OUT_REG(OUT_REG)
      ) u_db (
         .clk(clk), .rst_n(rst_n), .own_phase(own[c]),
         .tick(tick), .dead(act_dt), .gate(gates[c])
      );
   end

   if (OUT_REG) begin : g_mark_reg
      logic mq;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) mq <= 1'b0;
         else        mq <= mark_raw;
      end
      assign cycle_mark = mq;
   end else begin : g_mark_comb
      assign cycle_mark = mark_raw;
   end

   assign gate_hs = gates[0];
   assign gate_ls = gates[1];
endmodule

// File: rtl/gate_pair_pwm_chk.sv
module gate_pair_pwm_chk #(
   parameter bit OUT_REG = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic run_en,
   input logic gate_hs,
   input logic gate_ls,
   input logic cycle_mark
);
   a_r2_never_both: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hs && gate_ls));

   a_r3_hs_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hs) |-> !$past(gate_ls));

   a_r3_ls_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_ls) |-> !$past(gate_hs));

   a_r6_mark_single: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_mark |=> !cycle_mark);

   a_r6_mark_ls_off: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_mark |-> !gate_ls);

   if (OUT_REG) begin : g_r1_reg
      a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
         !run_en |=> (!gate_hs && !gate_ls && !cycle_mark));
   end else begin : g_r1_comb
      a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
         !run_en |-> (!gate_hs && !gate_ls && !cycle_mark));
   end
endmodule

bind gate_pair_pwm gate_pair_pwm_chk #(.OUT_REG(OUT_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .run_en(run_en),
   .gate_hs(gate_hs), .gate_ls(gate_ls), .cycle_mark(cycle_mark)
);

// File: tb/test_gate_pair_pwm.sv
module test_gate_pair_pwm;
   localparam int CNT_W = 16;
   localparam int DT_W  = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             run_en = 1'b0;
   logic [CNT_W-1:0] on_len = '0;
   logic [CNT_W-1:0] off_len = '0;
   logic [DT_W-1:0]  dead_len = '0;
   logic             load_stb = 1'b0;
   logic             gate_hs, gate_ls, cycle_mark;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // expectation state, built from the requirements
   int m_run, m_pos, m_on, m_off, m_dt, s_on, s_off, s_dt;

   always #2.5 clk = ~clk;

   gate_pair_pwm i_gate_pair_pwm (
      .clk(clk), .rst_n(rst_n), .run_en(run_en),
      .on_len(on_len), .off_len(off_len), .dead_len(dead_len),
      .load_stb(load_stb),
      .gate_hs(gate_hs), .gate_ls(gate_ls), .cycle_mark(cycle_mark)
   );

   function automatic int eff(input int x);
      return (x == 0) ? 1 : x;
   endfunction

   task automatic model_edge();
      int n_on, n_off, n_dt;
      if (!rst_n) begin
         m_run = 0; m_pos = 0;
         m_on = 4; m_off = 4; m_dt = 1;   // R10 defaults
         s_on = 4; s_off = 4; s_dt = 1;
         return;
      end
      n_on  = load_stb ? int'(on_len)   : s_on;
      n_off = load_stb ? int'(off_len)  : s_off;
      n_dt  = load_stb ? int'(dead_len) : s_dt;
      if (!run_en) begin
         m_run = 0; m_pos = 0;
      end else if (m_run == 0) begin
         m_run = 1; m_pos = 0;
         m_on = n_on; m_off = n_off; m_dt = n_dt;
      end else begin
         m_pos++;
         if (m_pos == eff(m_on) + eff(m_off)) begin
            m_pos = 0;
            m_on = n_on; m_off = n_off; m_dt = n_dt;
         end
      end
      if (load_stb) begin
         s_on = int'(on_len); s_off = int'(off_len); s_dt = int'(dead_len);
      end
   endtask

   task automatic check1(input string tag, input string what, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s actual %0b expected %0b (pos %0d)", tag, what, got, exp, m_pos);
      end
   endtask

   // one clock, then compare all outputs at the falling edge
   task automatic step(input string tag);
      bit act;
      int lon;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      act = (m_run != 0) && run_en && rst_n;
      lon = eff(m_on);
      check1(tag, "gate_hs", gate_hs, act && (m_pos < lon) && (m_pos >= m_dt));
      check1(tag, "gate_ls", gate_ls, act && (m_pos >= lon) && (m_pos - lon >= m_dt));
      check1(tag, "cycle_mark", cycle_mark, act && (m_pos == 0));
   endtask

   task automatic steps(input string tag, input int n);
      for (int i = 0; i < n; i++) step(tag);
   endtask

   task automatic strobe(input string tag, input int a, input int b, input int d);
      on_len = CNT_W'(a); off_len = CNT_W'(b); dead_len = DT_W'(d);
      load_stb = 1'b1;
      step(tag);
      load_stb = 1'b0;
   endtask

   task automatic t_reset();
      run_en = 1'b1;
      steps("R1", 5);
      run_en = 1'b0;
      rst_n = 1'b1;
      steps("R1", 3);
   endtask

   task automatic t_defaults();
      run_en = 1'b1;
      steps("R10", 20);   // also R5 R3 R2 R6
   endtask

   task automatic t_update();
      steps("R5", 2);
      strobe("R7", 6, 3, 2);
      steps("R7", 30);
   endtask

   task automatic t_multi();
      strobe("R7", 9, 9, 3);
      steps("R7", 1);
      strobe("R7", 5, 7, 2);
      steps("R7", 40);
   endtask

   task automatic t_short();
      strobe("R4", 2, 5, 3);
      steps("R4", 30);
   endtask

   task automatic t_zero();
      strobe("R8", 0, 3, 1);
      steps("R8", 20);
      strobe("R8", 4, 0, 1);
      steps("R8", 20);
   endtask

   task automatic t_boundary();
      strobe("R3", 5, 5, 1);
      while (m_pos != eff(m_on) + eff(m_off) - 1) step("R9");
      strobe("R9", 3, 8, 2);
      steps("R9", 25);
   endtask

   task automatic t_disable();
      strobe("R3", 7, 6, 2);
      steps("R3", 9);
      run_en = 1'b0;
      steps("R1", 4);
      run_en = 1'b1;
      steps("R1", 30);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      model_edge();
      @(negedge clk);
      t_reset();
      t_defaults();
      t_update();
      t_multi();
      t_short();
      t_zero();
      t_boundary();
      t_disable();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule